// File: doc/BRIEF.md
# Sampled Phase-Frequency Comparator

This block compares two edge streams, a reference clock and the divided-down feedback from an oscillator, and issues raise and lower requests to a charge pump. Both streams are sampled by a fast system clock. Each stream passes through a synchronizer and a rising-edge detector, and a three-state decision machine acts on the detected edges. The decision machine responds to frequency error as well as to phase error, so a loop built around it cannot settle on a harmonic or sub-harmonic of the reference.

A reference edge that arrives first opens a raise request. The request closes when the matching feedback edge arrives. The lower request is the mirror of this. The two requests are never active together, so no overlap pulse has to be cleared. When the loop is locked, both requests stay quiet for most of the time, and any remaining phase offset appears as short pulses whose width is a whole number of system-clock cycles.

The inputs and outputs are plain level signals with no handshake. A charge pump cannot apply back-pressure: each request is valid in every cycle in which it is high.

Top module: `freq_phase_comparator`

## Requirements
- R1: While rst_n is low, and after release until the first qualifying edge, up_o and dn_o are both 0.
- R2: In the idle state, a rising edge on ref_in with no rising edge on fb_in in the same sample sets up_o to 1. up_o is visible SYNC_STAGES+1 clock cycles after the input change (3 cycles at the default).
- R3: In the idle state, a rising edge on fb_in with no rising edge on ref_in in the same sample sets dn_o to 1, with the same latency as R2.
- R4: A rising edge on the opposite input while one request is active clears that request and returns the block to idle. The other request is not asserted.
- R5: While one request is active, further rising edges on its own input keep it asserted (saturation).
- R6: Rising edges on both inputs in the same sample cycle, seen from idle, leave the block idle.
- R7: up_o and dn_o are never 1 in the same cycle.
- R8: With ref_in faster than fb_in, only up_o pulses, and with ref_in slower only dn_o pulses. With equal frequencies and ref_in leading, only up_o pulses, for less than half the time. With equal frequencies and no offset, both outputs stay 0.
- R9: Falling edges and steady levels on either input change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference edge stream, may be asynchronous |
| fb_in | input | 1 | Divided feedback edge stream, may be asynchronous |
| up_o | output | 1 | Request to raise the oscillator control level |
| dn_o | output | 1 | Request to lower the oscillator control level |

## Verification
A decision machine stuck in the raise or lower state shows as a request that stays high across an opposite edge. The first feedback or reference edge that should close it reveals this SYNC_STAGES+1 cycles later. A state that swaps the raise and lower roles shows as the wrong request within one comparison period. A missing clear on a simultaneous edge, or a wrong clear on a same-side edge, changes the pulse pattern of the very next segment. Over a long run with different frequencies, any leak of the wrong request is counted, and a single stray cycle is enough to expose the fault.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    CMP_IDLE  = 2'b00,
    CMP_RAISE = 2'b01,
    CMP_LOWER = 2'b10
  } cmp_state_e;

  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;
  localparam int unsigned N_CH   = 2;

endpackage

// File: rtl/fpc_edge_tap.sv
module fpc_edge_tap #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= lvl_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], lvl_i};
      end
    end
  endgenerate

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign rise_o = synced & ~prev_q;

endmodule

// File: rtl/fpc_decider.sv
module fpc_decider
  import fpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_rise,
  input  logic       fb_rise,
  output cmp_state_e state_o
);

  cmp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CMP_IDLE: begin
        if (ref_rise && !fb_rise)      state_d = CMP_RAISE;
        else if (fb_rise && !ref_rise) state_d = CMP_LOWER;
      end
      CMP_RAISE: if (fb_rise)  state_d = CMP_IDLE;
      CMP_LOWER: if (ref_rise) state_d = CMP_IDLE;
      default: state_d = CMP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CMP_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/freq_phase_comparator.sv
module freq_phase_comparator
  import fpc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_o,
  output logic dn_o
);

  logic [N_CH-1:0] lvl_vec;
  logic [N_CH-1:0] rise_vec;
  logic            ref_rise;
  logic            fb_rise;
  cmp_state_e      state;

  assign lvl_vec[CH_REF] = ref_in;
  assign lvl_vec[CH_FB]  = fb_in;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_tap
      fpc_edge_tap #(.STAGES(SYNC_STAGES)) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl_vec[c]),
        .rise_o(rise_vec[c])
      );
    end
  endgenerate

  assign ref_rise = rise_vec[CH_REF];
  assign fb_rise  = rise_vec[CH_FB];

  fpc_decider u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .fb_rise (fb_rise),
    .state_o (state)
  );

  assign up_o = (state == CMP_RAISE);
  assign dn_o = (state == CMP_LOWER);

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
  input logic clk,
  input logic rst_n,
  input logic up,
  input logic dn,
  input logic ref_rise,
  input logic fb_rise
);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  p_raise_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && !dn && ref_rise && !fb_rise) |=> up);

  p_lower_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && !dn && fb_rise && !ref_rise) |=> dn);

  p_raise_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up && fb_rise) |=> (!up && !dn));

  p_lower_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && ref_rise) |=> (!up && !dn));

  p_raise_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !fb_rise) |=> up);

  p_lower_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && !ref_rise) |=> dn);

  p_tie_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && !dn && ref_rise && fb_rise) |=> (!up && !dn));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && !dn && !ref_rise && !fb_rise) |=> (!up && !dn));

endmodule

bind freq_phase_comparator fpc_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .up      (up_o),
  .dn      (dn_o),
  .ref_rise(ref_rise),
  .fb_rise (fb_rise)
);

// File: tb/freq_phase_comparator_bench.sv
`timescale 1ns/1ps
module freq_phase_comparator_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic up_o, dn_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  freq_phase_comparator u_freq_phase_comparator (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .up_o(up_o), .dn_o(dn_o)
  );

  // each entry {ref, fb, expected up, expected dn}; held 4 cycles, checked at the end
  localparam int NV = 19;
  localparam logic [3:0] VEC [NV] = '{
    4'b0000, 4'b1010, 4'b0010, 4'b1010, 4'b0010,
    4'b0100, 4'b0000, 4'b0101, 4'b0001, 4'b1000,
    4'b0000, 4'b1100, 4'b0000, 4'b1010, 4'b1100,
    4'b0000, 4'b0101, 4'b1100, 4'b0000
  };

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual up,dn=%b expected %b", req, act, exp);
    end
  endtask

  task automatic check_int(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    ref_in = 1'b0; fb_in = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // periodic run; returns cycles of up, of dn, and of overlap
  task automatic run_periodic(int pr, int pf, int fb_lag, int cyc,
                              output int n_up, output int n_dn, output int n_both);
    n_up = 0; n_dn = 0; n_both = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (up_o) n_up++;
      if (dn_o) n_dn++;
      if (up_o && dn_o) n_both++;
      ref_in = (k % pr) < (pr / 2);
      fb_in  = ((k + pf - fb_lag) % pf) < (pf / 2);
    end
  endtask

  initial begin
    int n_up, n_dn, n_both;
    // R1: reset holds outputs low even with edges on the inputs
    repeat (2) @(negedge clk);
    ref_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 during reset", {up_o, dn_o}, 2'b00);
    ref_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {up_o, dn_o}, 2'b00);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      ref_in = VEC[i][3]; fb_in = VEC[i][2];
      repeat (4) @(negedge clk);
      check($sformatf("table step %0d R2 R3 R4 R5 R6 R9", i),
            {up_o, dn_o}, VEC[i][1:0]);
    end

    // R2 latency: visible on third sample, not second
    do_reset();
    ref_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 not before latency", {up_o, dn_o}, 2'b00);
    @(negedge clk);
    check("R2 at latency", {up_o, dn_o}, 2'b10);

    // R1: reset in raise state clears at once
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears raise", {up_o, dn_o}, 2'b00);

    // R3 latency
    do_reset();
    fb_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 at latency", {up_o, dn_o}, 2'b01);

    // R8 / R7: faster reference
    do_reset();
    run_periodic(10, 14, 0, 1400, n_up, n_dn, n_both);
    check_int("R7 fast ref overlap", n_both == 0, n_both, 0);
    check_int("R8 fast ref no dn", n_dn == 0, n_dn, 0);
    check_int("R8 fast ref up present", n_up > 0, n_up, 1);

    // R8 / R7: slower reference
    do_reset();
    run_periodic(14, 10, 0, 1400, n_up, n_dn, n_both);
    check_int("R7 slow ref overlap", n_both == 0, n_both, 0);
    check_int("R8 slow ref no up", n_up == 0, n_up, 0);
    check_int("R8 slow ref dn present", n_dn > 0, n_dn, 1);

    // R8: equal frequency, reference leads by 3 cycles
    do_reset();
    run_periodic(12, 12, 3, 1200, n_up, n_dn, n_both);
    check_int("R8 lead no dn", n_dn == 0, n_dn, 0);
    check_int("R8 lead up present", n_up > 0, n_up, 1);
    check_int("R8 lead mostly idle", n_up * 2 < 1200, n_up, 600);

    // R8 / R6: equal frequency, in phase
    do_reset();
    run_periodic(12, 12, 0, 1200, n_up, n_dn, n_both);
    check_int("R8 in phase quiet", (n_up + n_dn) == 0, n_up + n_dn, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule